// File: doc/BRIEF.md
# Single-Line MSI Coherence Controller

This block keeps one processor's private one-word cache line coherent with the rest of the machine. The processor issues loads, stores and evictions. The controller talks to a home directory and to peer caches through a point-to-point network, and that network may deliver messages in any order. The line is held stably as I (invalid), S (shared, read-only) or M (modified, exclusive, dirty). A load miss is always granted in S, and only a store brings the line to M. While a transaction is open the controller sits in a transient state and holds off new processor requests.

When this node owns the line, it sends data straight to whichever node requested it. For a forwarded read it also sends a copy back to home, so a miss resolves in three hops. When an invalidation strips a shared copy, the node that caused it is remembered as the likely owner. On the next load miss the controller sends a speculative read to that node and also sends the normal request to home. A speculative reply can therefore finish the load in two hops, while the home reply still installs the line.

The receive side is a one-message mailbox. `rx_ready` rises only when the presented message is taken in that cycle. A message that the current state cannot act on stays in the mailbox until the sender removes it. The send side is never back-pressured. One incoming event can create two outgoing messages, and these leave on consecutive cycles.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset the line is I with no remembered owner. `cpu_req_ready` is 1, and `tx_valid`, `cpu_resp_valid` and `rx_ready` are 0. Processor op codes: 0 load, 1 store, 2 evict. Message codes: 0 GETS, 1 GETM, 2 PUTS, 3 PUTM, 4 DATA, 5 FWD_GETS, 6 FWD_GETM, 7 INV, 8 INV_ACK, 9 PUT_ACK, 10 SPEC_GETS, 11 SPEC_DATA, 12 SPEC_NACK. The home node id is `HOME_ID` (0) and this node's id is `MY_ID` (1).
- R2: A load in I sends GETS to home. A DATA reply then returns its word on `cpu_resp_rdata` and leaves the line in S. A load in S or M responds on the cycle after acceptance with the held word and sends no message.
- R3: A store in I sends GETM to home. The store completes only after a DATA reply has arrived and as many INV_ACKs have arrived as the DATA message's `rx_acks` field names. These messages may arrive in any order. The response carries the stored word.
- R4: A store in M completes on the cycle after acceptance with no message. A later load returns the newest stored word.
- R5: A store in S sends GETM to home and completes as in R3. An INV that arrives during this upgrade is answered with INV_ACK to its source.
- R6: A FWD_GETS taken in M sends DATA carrying the word to the requester named in `rx_src`. On the next cycle it sends the same DATA to home. The line becomes S.
- R7: A FWD_GETM taken in M sends DATA carrying the word to the requester, and the line becomes I.
- R8: An INV taken in S sends INV_ACK to `rx_src`, moves the line to I, and remembers `rx_src` as the predicted owner.
- R9: A load in I with a predicted owner sends SPEC_GETS to that node. On the next cycle it sends GETS to home. The prediction is then cleared, so the next miss sends only GETS.
- R10: During a load miss, a SPEC_DATA reply completes the load with its word at once, and the later home DATA installs the line without a second response. After a SPEC_NACK the load completes only on the home DATA. A speculative reply that arrives in any other state is taken with no effect.
- R11: A SPEC_GETS taken in M is answered with SPEC_DATA carrying the word to its source, and the line stays M. In every other state it is answered with SPEC_NACK.
- R12: An evict in M sends PUTM with the word to home, and an evict in S sends PUTS to home. Either one waits for PUT_ACK, during which `cpu_req_ready` is 0. An evict in I sends nothing. Every evict responds on the cycle after acceptance.
- R13: During a write-back, a FWD_GETS sends DATA to the requester and then to home, and a FWD_GETM sends DATA to the requester. After PUT_ACK the line is I.
- R14: While a transaction is open `cpu_req_ready` is 0. A message with no action in the current state (for example FWD_GETS in I) is held, and `rx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_req_wdata | input | DW | Store word |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DW | Loaded or stored word |
| rx_valid | input | 1 | Mailbox holds a message |
| rx_type | input | 4 | Message code |
| rx_src | input | NW | Sender id, or the requester for forwarded messages and INV |
| rx_data | input | DW | Message word |
| rx_acks | input | NW+1 | INV_ACK count carried by DATA from home |
| rx_ready | output | 1 | Message consumed this cycle |
| tx_valid | output | 1 | Outgoing message present (one per cycle) |
| tx_type | output | 4 | Message code |
| tx_src | output | NW | This node's id |
| tx_dst | output | NW | Destination id |
| tx_data | output | DW | Message word |

## Verification
A wrong transient or stable state shows up at the ports within a cycle or two. Either `rx_ready` stays low for a message that should be taken, or the wrong reply type, destination or word appears on `tx_*` in the cycle after the message is consumed. A bad ack count or a lost speculative flag shows as a missing, early or doubled `cpu_resp_valid` pulse. A corrupted word surfaces on the next load hit or in the next DATA/PUTM payload. Random load, store, evict and external-message traffic is compared against a three-state model with its own predicted-owner record. Directed cases cover the write-back races, reordered acks and stale speculative replies.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2
  } cpu_op_e;

  typedef enum logic [3:0] {
    M_GETS      = 4'd0,
    M_GETM      = 4'd1,
    M_PUTS      = 4'd2,
    M_PUTM      = 4'd3,
    M_DATA      = 4'd4,
    M_FWD_GETS  = 4'd5,
    M_FWD_GETM  = 4'd6,
    M_INV       = 4'd7,
    M_INV_ACK   = 4'd8,
    M_PUT_ACK   = 4'd9,
    M_SPEC_GETS = 4'd10,
    M_SPEC_DATA = 4'd11,
    M_SPEC_NACK = 4'd12
  } msg_e;

  typedef enum logic [3:0] {
    ST_I, ST_S, ST_M,
    ST_IS_D,   // load miss, waiting for data
    ST_IM_AD,  // store miss, waiting for data and acks
    ST_IM_A,   // store miss, data in, acks outstanding
    ST_SM_AD,  // upgrade, waiting for data and acks
    ST_MI_A,   // dirty write-back, waiting for PUT_ACK
    ST_SI_A,   // clean drop, waiting for PUT_ACK
    ST_II_A    // line given away during write-back, waiting for PUT_ACK
  } line_st_e;
endpackage

// File: rtl/msi_tx_stage.sv
// Registered send port. Takes up to two messages in one cycle and emits
// them on consecutive cycles; busy is high while the second is held.
module msi_tx_stage #(
  parameter int NW = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_a,
  input  logic [3:0]    a_t,
  input  logic [NW-1:0] a_d,
  input  logic [DW-1:0] a_x,
  input  logic          ld_b,
  input  logic [3:0]    b_t,
  input  logic [NW-1:0] b_d,
  input  logic [DW-1:0] b_x,
  output logic          busy,
  output logic          out_v,
  output logic [3:0]    out_t,
  output logic [NW-1:0] out_d,
  output logic [DW-1:0] out_x
);
  logic          pend_v;
  logic [3:0]    pend_t;
  logic [NW-1:0] pend_d;
  logic [DW-1:0] pend_x;

  assign busy = pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_t <= '0;
      pend_d <= '0;
      pend_x <= '0;
      out_v  <= 1'b0;
      out_t  <= '0;
      out_d  <= '0;
      out_x  <= '0;
    end else if (pend_v) begin
      out_v  <= 1'b1;
      out_t  <= pend_t;
      out_d  <= pend_d;
      out_x  <= pend_x;
      pend_v <= 1'b0;
    end else begin
      out_v <= ld_a;
      if (ld_a) begin
        out_t <= a_t;
        out_d <= a_d;
        out_x <= a_x;
      end
      pend_v <= ld_a && ld_b;
      if (ld_b) begin
        pend_t <= b_t;
        pend_d <= b_d;
        pend_x <= b_x;
      end
    end
  end
endmodule

// File: rtl/msi_ack_tracker.sv
// Balances the ack count carried by DATA against received INV_ACKs.
// Offers, from registered state only, whether the next event would finish.
module msi_ack_tracker #(
  parameter int NW = 2,
  localparam int CW = NW + 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        data_evt,
  input  logic        ack_evt,
  input  logic [NW:0] acks,
  output logic        done_if_data,
  output logic        done_if_ack
);
  logic [CW-1:0] bal;
  logic          got;
  logic [CW-1:0] acks_x;

  assign acks_x       = {1'b0, acks};
  assign done_if_data = (bal + acks_x) == '0;
  assign done_if_ack  = got && (bal == CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bal <= '0;
      got <= 1'b0;
    end else if (data_evt) begin
      bal <= bal + acks_x;
      got <= 1'b1;
    end else if (ack_evt) begin
      bal <= bal - CW'(1);
    end
  end
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int NW      = 2,
  parameter int DW      = 16,
  parameter int MY_ID   = 1,
  parameter int HOME_ID = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req_valid,
  input  logic [1:0]    cpu_req_op,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_req_ready,
  output logic          cpu_resp_valid,
  output logic [DW-1:0] cpu_resp_rdata,
  input  logic          rx_valid,
  input  logic [3:0]    rx_type,
  input  logic [NW-1:0] rx_src,
  input  logic [DW-1:0] rx_data,
  input  logic [NW:0]   rx_acks,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [3:0]    tx_type,
  output logic [NW-1:0] tx_src,
  output logic [NW-1:0] tx_dst,
  output logic [DW-1:0] tx_data
);
  localparam logic [NW-1:0] HOME = NW'(HOME_ID);
  localparam logic [NW-1:0] SELF = NW'(MY_ID);

  line_st_e      st, st_n;
  logic [DW-1:0] line_q, line_n, wbuf_q, wbuf_n;
  logic          pv_q, pv_n, spec_q, spec_n;
  logic [NW-1:0] pid_q, pid_n;
  logic          rv_n;
  logic [DW-1:0] rd_n;

  logic          ld_a, ld_b;
  msg_e          a_t, b_t;
  logic [NW-1:0] a_d, b_d;
  logic [DW-1:0] a_x, b_x;
  logic          tx_busy, stable, acc;
  logic          trk_clr, trk_data, trk_ack, done_if_data, done_if_ack;
  msg_e          rmsg;
  cpu_op_e       cop;

  assign rmsg          = msg_e'(rx_type);
  assign cop           = cpu_op_e'(cpu_req_op);
  assign stable        = (st == ST_I) || (st == ST_S) || (st == ST_M);
  assign cpu_req_ready = stable && !tx_busy && !rx_valid;
  assign rx_ready      = acc;
  assign tx_src        = SELF;

  always_comb begin
    st_n = st;  line_n = line_q;  wbuf_n = wbuf_q;
    pv_n = pv_q;  pid_n = pid_q;  spec_n = spec_q;
    rv_n = 1'b0;  rd_n = line_q;
    ld_a = 1'b0;  a_t = M_DATA;  a_d = HOME;  a_x = line_q;
    ld_b = 1'b0;  b_t = M_DATA;  b_d = HOME;  b_x = line_q;
    acc = 1'b0;  trk_clr = 1'b0;  trk_data = 1'b0;  trk_ack = 1'b0;

    if (rx_valid && !tx_busy) begin
      if (rmsg == M_SPEC_GETS) begin
        acc = 1'b1;  ld_a = 1'b1;  a_d = rx_src;
        a_t = (st == ST_M) ? M_SPEC_DATA : M_SPEC_NACK;
      end else if (rmsg == M_SPEC_DATA || rmsg == M_SPEC_NACK) begin
        acc = 1'b1;
        if (st == ST_IS_D && rmsg == M_SPEC_DATA && !spec_q) begin
          spec_n = 1'b1;  rv_n = 1'b1;  rd_n = rx_data;
        end
      end else begin
        unique case (st)
          ST_S: if (rmsg == M_INV) begin
            acc = 1'b1;  ld_a = 1'b1;  a_t = M_INV_ACK;  a_d = rx_src;
            st_n = ST_I;  pv_n = 1'b1;  pid_n = rx_src;
          end
          ST_M, ST_MI_A: if (rmsg == M_FWD_GETS || rmsg == M_FWD_GETM) begin
            acc = 1'b1;  ld_a = 1'b1;  a_t = M_DATA;  a_d = rx_src;
            ld_b = (rmsg == M_FWD_GETS);
            if (st == ST_M) st_n = (rmsg == M_FWD_GETS) ? ST_S : ST_I;
            else            st_n = (rmsg == M_FWD_GETS) ? ST_SI_A : ST_II_A;
          end else if (rmsg == M_PUT_ACK && st == ST_MI_A) begin
            acc = 1'b1;  st_n = ST_I;
          end
          ST_IS_D: if (rmsg == M_DATA) begin
            acc = 1'b1;  line_n = rx_data;  st_n = ST_S;
            if (!spec_q) begin
              rv_n = 1'b1;  rd_n = rx_data;
            end
          end
          ST_IM_AD, ST_SM_AD: begin
            if (rmsg == M_DATA) begin
              acc = 1'b1;  trk_data = 1'b1;  line_n = rx_data;
              if (done_if_data) begin
                st_n = ST_M;  line_n = wbuf_q;  rv_n = 1'b1;  rd_n = wbuf_q;
              end else begin
                st_n = ST_IM_A;
              end
            end else if (rmsg == M_INV_ACK) begin
              acc = 1'b1;  trk_ack = 1'b1;
            end else if (rmsg == M_INV && st == ST_SM_AD) begin
              acc = 1'b1;  ld_a = 1'b1;  a_t = M_INV_ACK;  a_d = rx_src;
              st_n = ST_IM_AD;
            end
          end
          ST_IM_A: if (rmsg == M_INV_ACK) begin
            acc = 1'b1;  trk_ack = 1'b1;
            if (done_if_ack) begin
              st_n = ST_M;  line_n = wbuf_q;  rv_n = 1'b1;  rd_n = wbuf_q;
            end
          end
          ST_SI_A: if (rmsg == M_INV) begin
            acc = 1'b1;  ld_a = 1'b1;  a_t = M_INV_ACK;  a_d = rx_src;
            st_n = ST_II_A;
          end else if (rmsg == M_PUT_ACK) begin
            acc = 1'b1;  st_n = ST_I;
          end
          ST_II_A: if (rmsg == M_PUT_ACK) begin
            acc = 1'b1;  st_n = ST_I;
          end
          default: ;
        endcase
      end
    end else if (cpu_req_valid && cpu_req_ready) begin
      unique case (cop)
        OP_LOAD: if (st == ST_I) begin
          ld_a = 1'b1;  st_n = ST_IS_D;  spec_n = 1'b0;
          if (pv_q) begin
            a_t = M_SPEC_GETS;  a_d = pid_q;
            ld_b = 1'b1;  b_t = M_GETS;  pv_n = 1'b0;
          end else begin
            a_t = M_GETS;
          end
        end else begin
          rv_n = 1'b1;
        end
        OP_STORE: if (st == ST_M) begin
          line_n = cpu_req_wdata;  rv_n = 1'b1;  rd_n = cpu_req_wdata;
        end else begin
          ld_a = 1'b1;  a_t = M_GETM;  wbuf_n = cpu_req_wdata;  trk_clr = 1'b1;
          st_n = (st == ST_S) ? ST_SM_AD : ST_IM_AD;
        end
        default: begin
          rv_n = 1'b1;
          if (st == ST_M) begin
            ld_a = 1'b1;  a_t = M_PUTM;  st_n = ST_MI_A;
          end else if (st == ST_S) begin
            ld_a = 1'b1;  a_t = M_PUTS;  st_n = ST_SI_A;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_I;  line_q <= '0;  wbuf_q <= '0;
      pv_q <= 1'b0;  pid_q <= '0;  spec_q <= 1'b0;
      cpu_resp_valid <= 1'b0;  cpu_resp_rdata <= '0;
    end else begin
      st <= st_n;  line_q <= line_n;  wbuf_q <= wbuf_n;
      pv_q <= pv_n;  pid_q <= pid_n;  spec_q <= spec_n;
      cpu_resp_valid <= rv_n;
      if (rv_n) cpu_resp_rdata <= rd_n;
    end
  end

  msi_tx_stage #(.NW(NW), .DW(DW)) u_tx (
    .clk(clk), .rst(rst),
    .ld_a(ld_a), .a_t(a_t), .a_d(a_d), .a_x(a_x),
    .ld_b(ld_b), .b_t(b_t), .b_d(b_d), .b_x(b_x),
    .busy(tx_busy),
    .out_v(tx_valid), .out_t(tx_type), .out_d(tx_dst), .out_x(tx_data)
  );

  msi_ack_tracker #(.NW(NW)) u_ack (
    .clk(clk), .rst(rst), .clear(trk_clr),
    .data_evt(trk_data), .ack_evt(trk_ack), .acks(rx_acks),
    .done_if_data(done_if_data), .done_if_ack(done_if_ack)
  );
endmodule

// File: rtl/msi_cache_ctrl_chk.sv
module msi_cache_ctrl_chk #(
  parameter int NW      = 2,
  parameter int HOME_ID = 0
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req_valid,
  input logic [1:0]    cpu_req_op,
  input logic          cpu_req_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [3:0]    rx_type,
  input logic [NW-1:0] rx_src,
  input logic          tx_valid,
  input logic [3:0]    tx_type,
  input logic [NW-1:0] tx_dst,
  input logic [3:0]    st
);
  localparam logic [NW-1:0] HOME = NW'(HOME_ID);
  logic rx_fire;
  assign rx_fire = rx_valid && rx_ready;

  p_spec_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_type == 4'd10) |=> (tx_valid && tx_type == 4'd0 && tx_dst == HOME));

  p_fwd_gets_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_fire && rx_type == 4'd5) |=>
      (tx_valid && tx_type == 4'd4 && tx_dst == $past(rx_src))
      ##1 (tx_valid && tx_type == 4'd4 && tx_dst == HOME));

  p_inv_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_fire && rx_type == 4'd7) |=>
      (tx_valid && tx_type == 4'd8 && tx_dst == $past(rx_src)));

  p_spec_reply_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_fire && rx_type == 4'd10) |=>
      (tx_valid && (tx_type == 4'd11 || tx_type == 4'd12) && tx_dst == $past(rx_src)));

  p_putm_r12: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready && cpu_req_op == 2'd2 && st == 4'd2) |=>
      (tx_valid && tx_type == 4'd3 && tx_dst == HOME && !cpu_req_ready));
endmodule

bind msi_cache_ctrl msi_cache_ctrl_chk #(.NW(NW), .HOME_ID(HOME_ID)) u_chk (
  .clk(clk), .rst(rst),
  .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_req_ready(cpu_req_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type), .rx_src(rx_src),
  .tx_valid(tx_valid), .tx_type(tx_type), .tx_dst(tx_dst),
  .st(st)
);

// File: tb/msi_cache_ctrl_tb.sv
`timescale 1ns/1ps
module msi_cache_ctrl_tb;
  localparam int NW = 2, DW = 16;
  localparam logic [3:0] GETS = 0, GETM = 1, PUTS = 2, PUTM = 3, DATA = 4,
    FGETS = 5, FGETM = 6, INV = 7, IACK = 8, PACK = 9, SGETS = 10, SDATA = 11, SNACK = 12;
  localparam logic [NW-1:0] HOME = 0;
  localparam int SI = 0, SS = 1, SM = 2;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic cpu_req_valid = 0;  logic [1:0] cpu_req_op = 0;  logic [DW-1:0] cpu_req_wdata = 0;
  logic cpu_req_ready, cpu_resp_valid;  logic [DW-1:0] cpu_resp_rdata;
  logic rx_valid = 0;  logic [3:0] rx_type = 0;  logic [NW-1:0] rx_src = 0;
  logic [DW-1:0] rx_data = 0;  logic [NW:0] rx_acks = 0;  logic rx_ready;
  logic tx_valid;  logic [3:0] tx_type;  logic [NW-1:0] tx_src, tx_dst;  logic [DW-1:0] tx_data;

  msi_cache_ctrl #(.NW(NW), .DW(DW), .MY_ID(1), .HOME_ID(0)) u_dut (.*);

  int nchk = 0, nfail = 0;
  logic [21:0] txq [0:63];
  logic [5:0]  tx_wr = 0, tx_rd = 0;
  int resp_pend = 0;
  logic [DW-1:0] resp_last;

  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      txq[tx_wr] <= {tx_type, tx_dst, tx_data};
      tx_wr <= tx_wr + 1;
    end
    if (!rst && cpu_resp_valid) begin
      resp_pend <= resp_pend + 1;
      resp_last <= cpu_resp_rdata;
    end
  end

  // model of the line
  int m_st = SI;  logic [DW-1:0] m_word = 0;  bit m_pv = 0;  logic [NW-1:0] m_pid = 0;

  function automatic int st_after_op(int s, int op);
    if (op == 0) return (s == SI) ? SS : s;
    if (op == 1) return SM;
    return SI;
  endfunction
  function automatic int st_after_fwd(bit is_getm);
    return is_getm ? SI : SS;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic cpu(input logic [1:0] op, input logic [DW-1:0] wd);
    for (int i = 0; i < 50 && !cpu_req_ready; i++) tick();
    cpu_req_valid = 1;  cpu_req_op = op;  cpu_req_wdata = wd;
    @(posedge clk); #1;
    cpu_req_valid = 0;
  endtask

  task automatic rx(input logic [3:0] t, input logic [NW-1:0] s,
                    input logic [DW-1:0] d, input logic [NW:0] k);
    rx_valid = 1;  rx_type = t;  rx_src = s;  rx_data = d;  rx_acks = k;
    #0.2;
    for (int i = 0; i < 50 && !rx_ready; i++) begin @(posedge clk); #0.2; end
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic exp_tx(input string tag, input logic [3:0] t, input logic [NW-1:0] d,
                        input logic [DW-1:0] x, input bit use_x);
    logic [21:0] e;
    for (int i = 0; i < 20 && tx_wr == tx_rd; i++) tick();
    if (tx_wr == tx_rd) begin
      chk(tag, 32'hdead, {t, d, x});
    end else begin
      e = txq[tx_rd];  tx_rd = tx_rd + 1;
      if (!use_x) e[DW-1:0] = x;
      chk(tag, e, {t, d, x});
    end
  endtask

  task automatic exp_resp(input string tag, input logic [DW-1:0] v, input bit use_v);
    for (int i = 0; i < 20 && resp_pend == 0; i++) tick();
    chk(tag, resp_pend > 0, 1);
    if (resp_pend > 0) begin
      if (use_v) chk(tag, resp_last, v);
      resp_pend = resp_pend - 1;
    end
  endtask

  task automatic settle(input string tag);
    tick(); tick(); tick();
    chk({tag, " quiet"}, {26'd0, tx_wr - tx_rd}, 0);
    chk({tag, " no extra resp"}, resp_pend, 0);
  endtask

  task automatic do_load(input int mode);
    logic [DW-1:0] v;
    int pre_st;
    pre_st = m_st;
    v = DW'($urandom);
    cpu(0, 0);
    if (m_st == SI) begin
      if (m_pv) begin
        exp_tx("R9 spec first", SGETS, m_pid, 0, 0);
        exp_tx("R9 home second", GETS, HOME, 0, 0);
        m_pv = 0;
        if (mode == 0) begin
          rx(SDATA, m_pid, v, 0);
          exp_resp("R10 spec data completes", v, 1);
          rx(DATA, HOME, v, 0);
        end else begin
          rx(SNACK, m_pid, 0, 0);
          tick();
          chk("R10 nack no resp", resp_pend, 0);
          rx(DATA, HOME, v, 0);
          exp_resp("R10 home completes", v, 1);
        end
      end else begin
        exp_tx("R2 GETS", GETS, HOME, 0, 0);
        chk("R14 stall in miss", cpu_req_ready, 0);
        rx(DATA, HOME, v, 0);
        exp_resp("R2 miss data", v, 1);
      end
      m_word = v;
    end else begin
      exp_resp("R2/R4 hit", m_word, 1);
    end
    m_st = st_after_op(pre_st, 0);
    settle("R2 load");
  endtask

  task automatic do_store(input logic [DW-1:0] v, input int k, input int pre);
    cpu(1, v);
    if (m_st == SM) begin
      exp_resp("R4 store hit", v, 1);
    end else begin
      exp_tx(m_st == SS ? "R5 upgrade GETM" : "R3 GETM", GETM, HOME, 0, 0);
      for (int i = 0; i < pre; i++) rx(IACK, 2'(2 + (i % 2)), 0, 0);
      if (pre == k) begin
        chk("R3 no early resp", resp_pend, 0);
        rx(DATA, HOME, DW'($urandom), (NW+1)'(k));
      end else begin
        rx(DATA, HOME, DW'($urandom), (NW+1)'(k));
        for (int i = pre; i < k - 1; i++) rx(IACK, 2'(2 + (i % 2)), 0, 0);
        tick();
        chk("R3 waits last ack", resp_pend, 0);
        rx(IACK, 3, 0, 0);
      end
      exp_resp("R3 store done", v, 1);
    end
    m_word = v;
    m_st = st_after_op(m_st, 1);
    settle("R3 store");
  endtask

  task automatic do_evict;
    cpu(2, 0);
    exp_resp("R12 evict resp", 0, 0);
    if (m_st == SM) begin
      exp_tx("R12 PUTM", PUTM, HOME, m_word, 1);
      chk("R12 stall", cpu_req_ready, 0);
      rx(PACK, HOME, 0, 0);
    end else if (m_st == SS) begin
      exp_tx("R12 PUTS", PUTS, HOME, 0, 0);
      chk("R12 stall", cpu_req_ready, 0);
      rx(PACK, HOME, 0, 0);
    end
    m_st = st_after_op(m_st, 2);
    settle("R12 evict");
  endtask

  task automatic do_ext(input logic [NW-1:0] p, input bit getm);
    if (m_st == SM) begin
      if (getm) begin
        rx(FGETM, p, 0, 0);
        exp_tx("R7 data to req", DATA, p, m_word, 1);
      end else begin
        rx(FGETS, p, 0, 0);
        exp_tx("R6 data to req", DATA, p, m_word, 1);
        exp_tx("R6 data to home", DATA, HOME, m_word, 1);
      end
      m_st = st_after_fwd(getm);
    end else if (m_st == SS) begin
      rx(INV, p, 0, 0);
      exp_tx("R8 inv ack", IACK, p, 0, 0);
      m_st = SI;  m_pv = 1;  m_pid = p;
    end else begin
      rx(SGETS, p, 0, 0);
      exp_tx("R11 nack when not M", SNACK, p, 0, 0);
    end
    settle("ext");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    tick();
    // R1 reset state
    chk("R1 ready", cpu_req_ready, 1);
    chk("R1 tx idle", tx_valid, 0);
    chk("R1 no resp", cpu_resp_valid, 0);
    // R14 held message in I
    rx_valid = 1; rx_type = FGETS; rx_src = 2; #0.2;
    for (int i = 0; i < 4; i++) begin chk("R14 held", rx_ready, 0); tick(); end
    rx_valid = 0;
    settle("R14");
    // R11 spec in I
    do_ext(3, 0);
    // R1/R2 first load, no prediction
    do_load(0);
    // R5 upgrade with acks first, then R4 hits
    do_store(16'h1111, 2, 2);
    do_store(16'h2222, 0, 0);
    do_load(0);
    // R11 spec in M
    rx(SGETS, 2, 0, 0);
    exp_tx("R11 spec data in M", SDATA, 2, 16'h2222, 1);
    settle("R11");
    do_store(16'h3333, 0, 0);
    // R13 write-back race with FWD_GETS
    cpu(2, 0);
    exp_resp("R12 evict resp", 0, 0);
    exp_tx("R12 PUTM", PUTM, HOME, 16'h3333, 1);
    rx(FGETS, 2, 0, 0);
    exp_tx("R13 data req", DATA, 2, 16'h3333, 1);
    exp_tx("R13 data home", DATA, HOME, 16'h3333, 1);
    rx(PACK, HOME, 0, 0);
    m_st = SI;
    settle("R13 gets");
    // R13 write-back race with FWD_GETM
    do_store(16'h4444, 1, 0);
    cpu(2, 0);
    exp_resp("R12 evict resp", 0, 0);
    exp_tx("R12 PUTM", PUTM, HOME, 16'h4444, 1);
    rx(FGETM, 3, 0, 0);
    exp_tx("R13 getm data req", DATA, 3, 16'h4444, 1);
    rx(PACK, HOME, 0, 0);
    m_st = SI;
    settle("R13 getm");
    do_load(0);                 // R13: I afterwards gives plain GETS
    // R5 INV during upgrade
    cpu(1, 16'h5555);
    exp_tx("R5 GETM", GETM, HOME, 0, 0);
    rx(INV, 2, 0, 0);
    exp_tx("R5 inv ack in upgrade", IACK, 2, 0, 0);
    rx(DATA, HOME, 16'h0, 0);
    exp_resp("R5 done", 16'h5555, 1);
    m_st = SM; m_word = 16'h5555;
    settle("R5");
    // R8/R9/R10 prediction paths
    do_ext(2, 0);
    do_ext(3, 0);
    do_load(0);
    rx(SNACK, 3, 0, 0);         // R10 stale speculative reply
    settle("R10 stale");
    do_load(0);
    do_ext(2, 0);
    do_load(1);
    do_load(0);                 // R9 prediction consumed: hit
    // random phase
    for (int n = 0; n < 400; n++) begin
      int a;
      a = int'($urandom % 4);
      case (a)
        0: do_load(int'($urandom % 2));
        1: begin
             int k;
             k = int'($urandom % 3);
             do_store(DW'($urandom), k, int'($urandom % (k + 1)));
           end
        2: do_evict();
        default: do_ext(2'(2 + $urandom % 2), 1'($urandom));
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule